// File: doc/BRIEF.md
# Prioritized Transmit Buffer Manager

This block keeps a small set of transmit message buffers for a CAN FD style controller. Each buffer has its own state machine with five states: Empty, Ready, TransmittedOK, Error and Aborted. Each buffer also has a programmable 3-bit priority. Software-style register writes arrive as a command word. The word carries a select mask naming the buffers to act on, plus abort, set-ready and set-empty bits. Each selected buffer applies those bits in a fixed order.

An arbiter looks at every Ready buffer and picks the one with the highest priority. The block then hands that buffer's index to a frame transmitter over a start/done handshake. When the transmitter reports completion, three things happen:
- the buffer moves to TransmittedOK;
- a transmitted-frame counter advances;
- two interrupt request pulses fire.

Selection then repeats for as long as Ready buffers remain. A status output reports whether any buffer is Empty, and an idle output shows that no transmission is in flight. The frame transmitter itself sits outside this block and is represented only by the handshake.

Top module: `txbuf_mgr`

## Requirements
- R1: After reset every buffer is Empty, every priority is 0, the frame counter is 0, idle is 1, txnf is 1 and tx_start is 0.
- R2: The state codes are Empty=1, Ready=2, TransmittedOK=4, Error=5 and Aborted=6. Buffer i's state appears on buf_state bits [4i+3:4i]. Its priority is taken from prio_wdata bits [4i+2:4i], written as a whole word when prio_wr is 1.
- R3: Only Ready buffers with a nonzero priority can be chosen. The winner has the strictly greatest priority, and a tie goes to the lowest index.
- R4: For each selected buffer, the command bits act in this order: abort (Ready to Aborted), then set-ready (Empty, TransmittedOK, Error or Aborted to Ready), then set-empty (TransmittedOK, Error or Aborted to Empty). Each step sees the result of the step before it. Any other combination leaves the state unchanged.
- R5: While ctrl_en is 0, commands (including a counter clear) have no effect and no new transmission starts.
- R6: A selection takes one clock. tx_start is a one-cycle pulse, with tx_idx naming the chosen buffer. From that cycle until tx_done, idle is 0 and no other tx_start occurs.
- R7: A tx_done pulse during a transmission has these effects:
  - the buffer becomes TransmittedOK;
  - tx_frames increments;
  - irq_txdone and irq_bufchg each pulse for one cycle on the following cycle;
  - the next Ready buffer can be started right after.
- R8: A command aimed at the buffer being transmitted leaves that buffer's state unchanged; the transmission still completes to TransmittedOK.
- R9: txnf is 1 exactly when at least one buffer is Empty.
- R10: A command with cnt_clr set, while enabled, sets tx_frames to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable |
| cmd_valid | input | 1 | Command word write strobe |
| cmd_sel | input | NBUF (4) | Buffer select mask |
| cmd_abort | input | 1 | Abort command bit |
| cmd_ready | input | 1 | Set-ready command bit |
| cmd_empty | input | 1 | Set-empty command bit |
| cmd_cnt_clr | input | 1 | Clear transmitted-frame counter |
| prio_wr | input | 1 | Priority word write strobe |
| prio_wdata | input | 4*NBUF | Priority word, 3-bit field per buffer on a 4-bit pitch |
| tx_start | output | 1 | Start pulse to the transmitter |
| tx_idx | output | clog2(NBUF) | Index of buffer being transmitted |
| tx_done | input | 1 | Completion pulse from the transmitter |
| buf_state | output | 4*NBUF | Packed buffer states |
| tx_frames | output | CNT_W (16) | Transmitted-frame counter |
| irq_txdone | output | 1 | Transmit-done interrupt request pulse |
| irq_bufchg | output | 1 | Buffer-changed interrupt request pulse |
| txnf | output | 1 | Some buffer is Empty |
| idle | output | 1 | No transmission in flight |

## Verification
Several patterns exercise the arbiter:
- All four buffers are made Ready at once with mixed priorities, including a tie. This checks the full transmit order against strict-greatest, lowest-index ordering, and it separates a correct tie-break from a last-index or FIFO choice.
- A Ready buffer with priority 0 is left waiting. This shows whether zero is wrongly treated as a candidate.

Combined command bits are applied to a Ready buffer: abort with set-ready, and abort with set-empty. They give different end states depending on evaluation order, so a reordered chain is exposed.

A command is also sent to the buffer in flight, and another while the enable is low. These tell a correct lock apart from a design that lets commands through.

// File: rtl/txbm_pkg.sv
package txbm_pkg;
  localparam int FLD_W  = 4;
  localparam int PRIO_W = 3;

  localparam logic [FLD_W-1:0] ST_EMPTY = 4'd1;
  localparam logic [FLD_W-1:0] ST_READY = 4'd2;
  localparam logic [FLD_W-1:0] ST_TXOK  = 4'd4;
  localparam logic [FLD_W-1:0] ST_ERROR = 4'd5;
  localparam logic [FLD_W-1:0] ST_ABORT = 4'd6;

  // Fixed evaluation chain: abort, then set-ready, then set-empty.
  function automatic logic [FLD_W-1:0] apply_cmd(
    input logic [FLD_W-1:0] cur,
    input logic             do_abort,
    input logic             do_ready,
    input logic             do_empty
  );
    logic [FLD_W-1:0] s;
    s = cur;
    if (do_abort && s == ST_READY) s = ST_ABORT;
    if (do_ready && (s == ST_TXOK || s == ST_ERROR || s == ST_ABORT || s == ST_EMPTY))
      s = ST_READY;
    if (do_empty && (s == ST_TXOK || s == ST_ERROR || s == ST_ABORT))
      s = ST_EMPTY;
    return s;
  endfunction
endpackage

// File: rtl/txbm_buf.sv
module txbm_buf
  import txbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hit,
  input  logic             cmd_abort,
  input  logic             cmd_ready,
  input  logic             cmd_empty,
  input  logic             locked,
  input  logic             done_hit,
  output logic [FLD_W-1:0] state
);
  logic [FLD_W-1:0] state_nxt;
  logic             state_en;

  always_comb begin
    state_en  = done_hit | (cmd_hit & ~locked);
    state_nxt = state;
    if (done_hit)
      state_nxt = ST_TXOK;
    else if (cmd_hit && !locked)
      state_nxt = apply_cmd(state, cmd_abort, cmd_ready, cmd_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= ST_EMPTY;
    else if (state_en)
      state <= state_nxt;
  end

  // R2: only defined codes ever appear
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMPTY || state == ST_READY || state == ST_TXOK ||
     state == ST_ERROR || state == ST_ABORT));

  // R8: buffer in flight holds its state until completion
  a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !done_hit) |=> $stable(state));

  // R7: completion lands in TransmittedOK
  a_r7_done_txok: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> (state == ST_TXOK));
endmodule

// File: rtl/txbm_arb.sv
module txbm_arb
  import txbm_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF*FLD_W-1:0] states,
  input  logic [NBUF*FLD_W-1:0] prios,
  output logic                  found,
  output logic [IDX_W-1:0]      win_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (states[i*FLD_W +: FLD_W] == ST_READY &&
          prios[i*FLD_W +: PRIO_W] > best) begin
        best    = prios[i*FLD_W +: PRIO_W];
        win_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/txbm_seq.sv
module txbm_seq #(
  parameter int IDX_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             tx_done,
  input  logic             cnt_clr,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             tx_start,
  output logic             finish,
  output logic [CNT_W-1:0] count,
  output logic             irq_txdone,
  output logic             irq_bufchg
);
  logic             launch;
  logic             busy_nxt;
  logic [CNT_W-1:0] count_nxt;
  logic             count_en;

  always_comb begin
    launch    = ctrl_en & ~busy & found;
    finish    = busy & tx_done;
    busy_nxt  = launch ? 1'b1 : (finish ? 1'b0 : busy);
    count_en  = cnt_clr | finish;
    count_nxt = cnt_clr ? '0 : count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      tx_start   <= 1'b0;
      irq_txdone <= 1'b0;
      irq_bufchg <= 1'b0;
    end else begin
      busy       <= busy_nxt;
      tx_start   <= launch;
      irq_txdone <= finish;
      irq_bufchg <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_idx <= '0;
    else if (launch)
      cur_idx <= win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (count_en)
      count <= count_nxt;
  end

  // R5: nothing starts while disabled
  a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !busy) |=> !tx_start);

  // R6: a transmission in flight blocks any new start
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done) |=> (!tx_start && busy));

  // R7: completion advances the counter by one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !cnt_clr) |=> (count == $past(count) + CNT_W'(1)));

  // R7: completion raises the interrupt pulses
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (irq_txdone && irq_bufchg));

  // R10: clear forces zero
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));
endmodule

// File: rtl/txbuf_mgr.sv
module txbuf_mgr
  import txbm_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int CNT_W = 16,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int WRD_W = NBUF * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             cmd_valid,
  input  logic [NBUF-1:0]  cmd_sel,
  input  logic             cmd_abort,
  input  logic             cmd_ready,
  input  logic             cmd_empty,
  input  logic             cmd_cnt_clr,
  input  logic             prio_wr,
  input  logic [WRD_W-1:0] prio_wdata,
  output logic             tx_start,
  output logic [IDX_W-1:0] tx_idx,
  input  logic             tx_done,
  output logic [WRD_W-1:0] buf_state,
  output logic [CNT_W-1:0] tx_frames,
  output logic             irq_txdone,
  output logic             irq_bufchg,
  output logic             txnf,
  output logic             idle
);
  logic [WRD_W-1:0] prio_q;
  logic             cmd_live;
  logic             cnt_clr;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic             busy;
  logic             finish;
  logic [NBUF-1:0]  empty_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prio_q <= '0;
    else if (prio_wr)
      prio_q <= prio_wdata;
  end

  assign cmd_live = cmd_valid & ctrl_en;
  assign cnt_clr  = cmd_live & cmd_cnt_clr;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic lock_g;
    logic done_g;
    assign lock_g = busy & (tx_idx == IDX_W'(g));
    assign done_g = finish & (tx_idx == IDX_W'(g));

    txbm_buf u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_hit   (cmd_live & cmd_sel[g]),
      .cmd_abort (cmd_abort),
      .cmd_ready (cmd_ready),
      .cmd_empty (cmd_empty),
      .locked    (lock_g),
      .done_hit  (done_g),
      .state     (buf_state[g*FLD_W +: FLD_W])
    );

    assign empty_vec[g] = (buf_state[g*FLD_W +: FLD_W] == ST_EMPTY);
  end

  txbm_arb #(.NBUF(NBUF), .IDX_W(IDX_W)) u_arb (
    .states  (buf_state),
    .prios   (prio_q),
    .found   (found),
    .win_idx (win_idx)
  );

  txbm_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .found      (found),
    .win_idx    (win_idx),
    .tx_done    (tx_done),
    .cnt_clr    (cnt_clr),
    .busy       (busy),
    .cur_idx    (tx_idx),
    .tx_start   (tx_start),
    .finish     (finish),
    .count      (tx_frames),
    .irq_txdone (irq_txdone),
    .irq_bufchg (irq_bufchg)
  );

  assign txnf = |empty_vec;
  assign idle = ~busy;

  // R6: a started buffer is Ready with a nonzero priority
  a_r6_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (buf_state[tx_idx*FLD_W +: FLD_W] == ST_READY &&
                  prio_q[tx_idx*FLD_W +: PRIO_W] != '0 && !idle));

  // R3: no Ready candidate with nonzero priority means no start next cycle
  a_r3_no_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    !found |=> !tx_start);
endmodule

// File: tb/txbuf_mgr_tb.sv
`timescale 1ns/1ps
module txbuf_mgr_tb;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_en, cmd_valid, cmd_abort, cmd_ready, cmd_empty, cmd_cnt_clr;
  logic [3:0]  cmd_sel;
  logic        prio_wr;
  logic [15:0] prio_wdata;
  logic        tx_start, tx_done;
  logic [1:0]  tx_idx;
  logic [15:0] buf_state, tx_frames;
  logic        irq_txdone, irq_bufchg, txnf, idle;

  int checks = 0;
  int errors = 0;
  int tx_lat = 2;
  int irq_a = 0;
  int irq_b = 0;
  int exp_q[$];
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  txbuf_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_valid(cmd_valid),
    .cmd_sel(cmd_sel), .cmd_abort(cmd_abort), .cmd_ready(cmd_ready),
    .cmd_empty(cmd_empty), .cmd_cnt_clr(cmd_cnt_clr), .prio_wr(prio_wr),
    .prio_wdata(prio_wdata), .tx_start(tx_start), .tx_idx(tx_idx),
    .tx_done(tx_done), .buf_state(buf_state), .tx_frames(tx_frames),
    .irq_txdone(irq_txdone), .irq_bufchg(irq_bufchg), .txnf(txnf), .idle(idle)
  );

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(logic [3:0] sel, logic a, logic r, logic e, logic c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_abort = a; cmd_ready = r;
    cmd_empty = e; cmd_cnt_clr = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_sel = '0; cmd_abort = 1'b0; cmd_ready = 1'b0;
    cmd_empty = 1'b0; cmd_cnt_clr = 1'b0;
  endtask

  task automatic set_prio(logic [15:0] w);
    @(negedge clk);
    prio_wr = 1'b1; prio_wdata = w;
    @(negedge clk);
    prio_wr = 1'b0;
  endtask

  // Transmitter stub
  initial begin
    tx_done = 1'b0;
    forever begin
      @(negedge clk);
      if (tx_start) begin
        repeat (tx_lat - 1) @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
      end
    end
  end

  // Monitor: compare each start with the scoreboard queue (R3, R6)
  initial begin
    forever begin
      @(negedge clk);
      if (irq_txdone) irq_a++;
      if (irq_bufchg) irq_b++;
      if (tx_start) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected start actual=%0d expected=none", tx_idx);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (int'(tx_idx) != e) begin
            errors++;
            $display("FAIL R3 start order actual=%0d expected=%0d", tx_idx, e);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctrl_en = 1'b0; cmd_valid = 1'b0; cmd_sel = '0;
    cmd_abort = 1'b0; cmd_ready = 1'b0; cmd_empty = 1'b0; cmd_cnt_clr = 1'b0;
    prio_wr = 1'b0; prio_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 states", buf_state, 16'h1111);
    check_eq("R1 count", tx_frames, 0);
    check_eq("R1 idle", idle, 1);
    check_eq("R1 txnf", txnf, 1);
    check_eq("R1 start", tx_start, 0);

    // R5: disabled, commands ignored
    set_prio(16'h2331);
    do_cmd(4'hF, 0, 1, 0, 0);
    repeat (5) @(negedge clk);
    check_eq("R5 disabled cmd", buf_state, 16'h1111);
    check_eq("R5 no start idle", idle, 1);

    // R3/R6/R7: all ready, order 1,2,3,0 (tie 1 vs 2 -> 1)
    ctrl_en = 1'b1;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(0);
    do_cmd(4'hF, 0, 1, 0, 0);
    check_eq("R4 set-ready from empty", buf_state, 16'h2222);
    check_eq("R9 no empty", txnf, 0);
    repeat (40) @(negedge clk);
    check_eq("R3 queue drained", exp_q.size(), 0);
    check_eq("R7 all txok", buf_state, 16'h4444);
    check_eq("R7 count", tx_frames, 4);
    check_eq("R7 irq_txdone pulses", irq_a, 4);
    check_eq("R7 irq_bufchg pulses", irq_b, 4);
    check_eq("R9 none empty", txnf, 0);
    check_eq("R6 idle after", idle, 1);

    // R3: priority 0 never chosen
    set_prio(16'h2330);
    do_cmd(4'hF, 0, 0, 1, 0);
    check_eq("R4 set-empty from txok", buf_state, 16'h1111);
    do_cmd(4'h1, 0, 1, 0, 0);
    repeat (10) @(negedge clk);
    check_eq("R3 prio0 stays ready", buf_state, 16'h1112);
    check_eq("R9 some empty", txnf, 1);

    // R4 transitions and ordering
    do_cmd(4'h1, 1, 0, 0, 0);
    check_eq("R4 abort ready", buf_state, 16'h1116);
    do_cmd(4'h2, 1, 0, 1, 0);
    check_eq("R4 abort/empty on empty ignored", buf_state, 16'h1116);
    do_cmd(4'h1, 0, 1, 0, 0);
    check_eq("R4 ready from aborted", buf_state, 16'h1112);
    do_cmd(4'h1, 0, 0, 1, 0);
    check_eq("R4 empty on ready ignored", buf_state, 16'h1112);
    do_cmd(4'h1, 1, 1, 0, 0);
    check_eq("R4 abort then ready", buf_state, 16'h1112);
    do_cmd(4'h1, 1, 0, 1, 0);
    check_eq("R4 abort then empty", buf_state, 16'h1111);

    // R8: command to buffer in flight
    tx_lat = 10;
    set_prio(16'h5330);
    exp_q.push_back(3);
    do_cmd(4'h8, 0, 1, 0, 0);
    do_cmd(4'h8, 1, 0, 1, 0);
    check_eq("R8 locked during tx", buf_state, 16'h2111);
    check_eq("R6 busy", idle, 0);
    repeat (20) @(negedge clk);
    check_eq("R8 ends txok", buf_state, 16'h4111);
    check_eq("R7 count step", tx_frames, 5);

    // R5: clear ignored while disabled, R10: clear while enabled
    ctrl_en = 1'b0;
    do_cmd(4'h0, 0, 0, 0, 1);
    check_eq("R5 clear ignored", tx_frames, 5);
    ctrl_en = 1'b1;
    do_cmd(4'h0, 0, 0, 0, 1);
    check_eq("R10 clear", tx_frames, 0);

    repeat (5) @(negedge clk);
    check_eq("R3 no extra starts", exp_q.size(), 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule